// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

The block holds a byte-wide chain of stages that is either filled in parallel from a data bus or advanced one place toward the last stage. Each advance puts the serial input into stage 0. The last stage drives a true serial output and its complement. Shifting is triggered by rising edges of the OR of two shift-clock pins. Either pin can therefore serve as an active-high clock inhibit. A pin that rises while the other is low also counts as a clock edge.

All pins are sampled by a fast system clock through a synchronizer. Shift events come from an edge detector on the OR-ed clock. The load strobe is active low and level-sensitive, and it overrides clocking. The system clock ends the design. The shift pins are data, not clocks.

Top module: `piso_shift_reg`

## Requirements
- R1: While `load_ni` is low, every stage k follows `par_i[k]`, and changes of `par_i` during the low phase are tracked. Stage 7 is observed on `ser_o`.
- R2: While `load_ni` is low, transitions of `sclk_a_i` and `sclk_b_i` do not shift the register.
- R3: With `load_ni` high, each rising edge of `sclk_a_i | sclk_b_i` moves stage k to stage k+1 and puts `ser_i` into stage 0. `ser_o` is stage 7.
- R4: `sclk_a_i` and `sclk_b_i` act identically as shift clocks.
- R5: While one shift pin is held high, transitions of the other pin cause no shift.
- R6: A pin that rises while the other pin is low produces exactly one shift. Both pins rising in the same sample also produce exactly one shift.
- R7: With `load_ni` high and no rising edge of the OR-ed clock, the contents are held, whatever `ser_i` does.
- R8: `ser_n_o` is always the complement of `ser_o`.
- R9: A rising edge of the OR-ed clock seen in the same sample as the release of `load_ni` does not shift.
- R10: Asynchronous reset clears all stages. After reset `ser_o`=0 and `ser_n_o`=1. An input change takes effect at the third rising edge of `clk_i` after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Parallel load strobe, active low, level-sensitive |
| sclk_a_i | input | 1 | Shift clock pin A |
| sclk_b_i | input | 1 | Shift clock pin B |
| ser_i | input | 1 | Serial data into stage 0 |
| par_i | input | WIDTH | Parallel data, bit k feeds stage k |
| ser_o | output | 1 | Last stage |
| ser_n_o | output | 1 | Complement of last stage |

## Verification
The bench builds the block with its defaults: WIDTH=8 and SYNC_STAGES=2. With these values, a full byte is loaded and then shifted out over eight clock edges, so every stage is seen on the output. The two-stage synchronizer fixes the latency at three system edges. The bench uses this to check, at the edge itself, that a result arrives neither early nor late. The bench also makes both pins rise in the same sample and releases load on the same sample as a clock edge. These two cases exist only because of the sampled, single-clock model.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef struct packed {
    logic load_n;
    logic sclk_a;
    logic sclk_b;
    logic ser;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{load_n: 1'b1, sclk_a: 1'b0, sclk_b: 1'b0, ser: 1'b0};
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= RST_VAL;
        else         chain_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= RST_VAL;
        else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/piso_edge_det.sv
module piso_edge_det
  import piso_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_i,
  output logic  shift_o
);
  logic or_now, or_q, load_n_q;

  assign or_now = ctrl_i.sclk_a | ctrl_i.sclk_b;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      or_q     <= 1'b0;
      load_n_q <= 1'b1;
    end else begin
      or_q     <= or_now;
      load_n_q <= ctrl_i.load_n;
    end

  // mask edges while loading and in the sample that releases load
  assign shift_o = or_now & ~or_q & ctrl_i.load_n & load_n_q;

  AST_ONE_SHIFT_PER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |=> !shift_o); // R6
  AST_INHIBIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.sclk_a && $past(ctrl_i.sclk_a)) |-> !shift_o); // R5
endmodule

// File: rtl/piso_stages.sv
module piso_stages #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             shift_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       q_o <= '0;
    else if (!load_ni) q_o <= par_i;
    else if (shift_i)  q_o <= {q_o[WIDTH-2:0], ser_i};

  AST_LOAD_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> q_o == $past(par_i)); // R1
  AST_SHIFT_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && shift_i) |=> q_o == {$past(q_o[WIDTH-2:0]), $past(ser_i)}); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !shift_i) |=> $stable(q_o)); // R7
  AST_NO_SHIFT_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> $past(load_ni)); // R9
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             sclk_a_i,
  input  logic             sclk_b_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             ser_o,
  output logic             ser_n_o
);
  localparam int unsigned CW = $bits(ctrl_t);

  ctrl_t            ctrl_raw, ctrl_s;
  logic [WIDTH-1:0] par_s, stages_q;
  logic             shift_ev;

  assign ctrl_raw = '{load_n: load_ni, sclk_a: sclk_a_i, sclk_b: sclk_b_i, ser: ser_i};

  piso_sync #(.WIDTH(CW), .STAGES(SYNC_STAGES), .RST_VAL(CW'(CTRL_IDLE))) u_sync_ctrl (
    .clk_i, .rst_ni, .d_i(ctrl_raw), .q_o(ctrl_s)
  );

  piso_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_par (
    .clk_i, .rst_ni, .d_i(par_i), .q_o(par_s)
  );

  piso_edge_det u_edge (.clk_i, .rst_ni, .ctrl_i(ctrl_s), .shift_o(shift_ev));

  piso_stages #(.WIDTH(WIDTH)) u_stages (
    .clk_i, .rst_ni,
    .load_ni(ctrl_s.load_n), .shift_i(shift_ev), .ser_i(ctrl_s.ser),
    .par_i(par_s), .q_o(stages_q)
  );

  assign ser_o   = stages_q[WIDTH-1];
  assign ser_n_o = ~stages_q[WIDTH-1];
endmodule

// File: tb/tb_piso_shift_reg.sv
module tb_piso_shift_reg;
  localparam int W = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic load_ni = 1'b1, sclk_a = 1'b0, sclk_b = 1'b0, ser = 1'b0;
  logic [W-1:0] par = '0;
  logic ser_o, ser_n_o;
  logic [W-1:0] m = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  piso_shift_reg #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni, .load_ni, .sclk_a_i(sclk_a), .sclk_b_i(sclk_b),
    .ser_i(ser), .par_i(par), .ser_o, .ser_n_o
  );

  task automatic settle(int n = 3);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic exp);
    checks++;
    if (ser_o !== exp || ser_n_o !== ~exp) begin
      errors++;
      $display("FAIL %s: ser_o=%b ser_n_o=%b expected %b/%b", req, ser_o, ser_n_o, exp, ~exp);
    end
  endtask

  task automatic shift_in(logic b);
    m = {m[W-2:0], b};
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; settle(2); rst_ni = 1'b1; settle(3);
    m = '0;
    chk("R10 reset", 1'b0);
  endtask

  task automatic t_load;
    load_ni = 1'b0; par = 8'h00; settle(3); m = par; chk("R1 load 00", m[7]);
    par = 8'hFF; settle(2); chk("R10 not before third edge", 1'b0);
    settle(1); m = par; chk("R10 third edge", m[7]);
    par = 8'h35; settle(3); m = par; chk("R1 track", m[7]);
    sclk_a = 1'b1; settle(3); sclk_a = 1'b0; settle(3);
    sclk_b = 1'b1; settle(3); sclk_b = 1'b0; settle(3);
    chk("R2 no shift while loading", m[7]);
    par = 8'hA5; settle(3); m = par; chk("R1 reload", m[7]);
  endtask

  task automatic t_release;
    load_ni = 1'b1; sclk_a = 1'b1; settle(4);
    chk("R9 release edge ignored", m[7]);
    sclk_a = 1'b0; settle(3);
    chk("R9 still held", m[7]);
  endtask

  task automatic t_shift8;
    logic [W-1:0] pat = 8'b1100_1010;
    for (int i = 0; i < W; i++) begin
      ser = pat[i];
      if (i % 2 == 0) sclk_a = 1'b1; else sclk_b = 1'b1;
      settle(3); shift_in(pat[i]);
      chk(i % 2 == 0 ? "R3 shift pin a" : "R4 shift pin b", m[7]);
      sclk_a = 1'b0; sclk_b = 1'b0; settle(3);
    end
    chk("R3 serial byte out", pat[0]);
  endtask

  task automatic t_hold;
    for (int i = 0; i < 6; i++) begin ser = ~ser; settle(2); end
    chk("R7 hold", m[7]);
    chk("R8 complement", m[7]);
  endtask

  task automatic t_inhibit;
    ser = 1'b1; sclk_b = 1'b1; settle(3); shift_in(1'b1);
    chk("R6 gate rise shifts once", m[7]);
    ser = 1'b0;
    for (int i = 0; i < 4; i++) begin sclk_a = ~sclk_a; settle(3); end
    chk("R5 inhibit", m[7]);
    sclk_b = 1'b0; settle(3);
    chk("R5 inhibit release no edge", m[7]);
    for (int i = 0; i < 3; i++) begin
      ser = 1'b1; sclk_a = 1'b1; sclk_b = 1'b1; settle(3); shift_in(1'b1);
      sclk_a = 1'b0; sclk_b = 1'b0; settle(3);
    end
    chk("R6 both rise one shift", m[7]);
    ser = 1'b0;
    for (int i = 0; i < 5; i++) begin
      sclk_a = 1'b1; settle(3); shift_in(1'b0);
      sclk_a = 1'b0; settle(3);
    end
    chk("R6 count check", m[7]);
  endtask

  initial begin
    t_reset();
    t_load();
    t_release();
    t_shift8();
    t_hold();
    t_inhibit();
    t_reset();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule